// File: doc/BRIEF.md
# Dual-Termination External Bus Cycle Controller

This block is the bus master that runs single external read and write cycles for a 32-bit processor core. The requester presents an address, a three-bit address-space code, a direction and, for writes, a data word. The controller drives the address strobe, the data strobe and the read/write line. It holds these until the addressed slave ends the cycle. It then returns the read data, the port width that was used and the kind of termination that ended the cycle.

A slave can end a cycle in one of two ways. The first is a two-bit size acknowledge, sampled asynchronously, that reports the width of the slave's port for that one cycle only; read data from a narrow port arrives on the upper byte lanes and is moved down to the low end. The second is a single synchronous done strobe, which ends the cycle faster and always moves a full 32-bit word. When neither is present the cycle waits without limit. Burst transfers, arbitration, retry, bus errors and splitting of misaligned operands are not handled here.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it, both strobes are high (negated), `rsp_valid` is 0, `bus_doe` is 0 and `req_ready` is 1.
- R2: A request accepted at clock edge E0 asserts `bus_as_n` low after E0. A synchronous done strobe is honoured from edge E1 on. On the edge where it is seen, `rsp_valid` goes to 1 for one clock with `rsp_sync`=1, `rsp_width`=11 and all 32 bits of `bus_din` in `rsp_rdata`.
- R3: A nonzero size acknowledge seen at edge E1 is ignored and the cycle stays active. Size acknowledge ends a cycle at E2 at the earliest, with `rsp_sync`=0.
- R4: Size acknowledge encoding: 01 is an 8-bit port, 10 a 16-bit port and 11 a 32-bit port. A read returns `bus_din[31:24]`, `bus_din[31:16]` or `bus_din[31:0]` respectively, zero-extended into `rsp_rdata`, and the code is reported in `rsp_width`.
- R5: While the size acknowledge is 00 and the done strobe is low, the cycle stays active with strobes asserted and `rsp_valid` 0, for any number of clocks.
- R6: If the done strobe and a nonzero size acknowledge are both seen at the same edge, the cycle ends as synchronous: `rsp_sync`=1, `rsp_width`=11 and full 32-bit data.
- R7: `bus_addr`, `bus_fc` and `bus_rw` keep their values from the cycle's start until it ends.
- R8: In the clock after termination both strobes are high and `req_ready` is 0. A request held during that clock is not started until the following edge.
- R9: A write drives `bus_rw`=0, `bus_doe`=1 and `bus_dout` equal to the write data from the first clock. `bus_ds_n` goes low one clock after `bus_as_n`.
- R10: A read drives `bus_rw`=1 and `bus_doe`=0, and `bus_ds_n` goes low in the same clock as `bus_as_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a bus cycle (taken when `req_ready` is 1) |
| req_ready | output | 1 | Controller idle and able to start a cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 32 | Cycle address |
| req_fc | input | 3 | Address-space code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock pulse: cycle completed |
| rsp_rdata | output | 32 | Read data, steered to the low end |
| rsp_sync | output | 1 | 1 = ended by done strobe, 0 = by size acknowledge |
| rsp_width | output | 2 | Port width used (01 byte, 10 half, 11 word) |
| bus_addr | output | 32 | External address |
| bus_fc | output | 3 | External address-space code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_dout | output | 32 | Write data to the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 32 | Read data from the bus |
| bus_ack_size | input | 2 | Size acknowledge from slave (00 = wait) |
| bus_sync_done | input | 1 | Synchronous done strobe, active high |

## Verification
The done strobe and the size acknowledge can both be present at the same sampling edge, and the two ways of ending a cycle then compete. The bench holds a read in wait states past the second edge and then raises the done strobe together with an 8-bit size acknowledge and a data word whose lanes all differ. The result counts as correct only if the response reports a synchronous end, width 11 and the full word, not the byte taken from the top lane. A second case raises both signals at the first edge, where only the strobe is allowed to count.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        PW_WAIT = 2'b00,
        PW_BYTE = 2'b01,
        PW_HALF = 2'b10,
        PW_WORD = 2'b11
    } port_w_e;

endpackage

// File: rtl/bcc_term_decode.sv
// Decides whether the current clock ends the active cycle, and how.
module bcc_term_decode #(
    parameter int CNT_W      = 1,
    parameter int SYNC_EDGE  = 1,
    parameter int ASYNC_EDGE = 2
) (
    input  logic             active,
    input  logic [CNT_W-1:0] edge_cnt,
    input  logic             sync_done,
    input  logic [1:0]       ack_size,
    output logic             term_hit,
    output logic             term_sync,
    output logic [1:0]       term_width
);
    import bcc_pkg::*;

    localparam logic [CNT_W:0] SYNC_LIM  = (CNT_W+1)'(SYNC_EDGE);
    localparam logic [CNT_W:0] ASYNC_LIM = (CNT_W+1)'(ASYNC_EDGE);

    logic [CNT_W:0] edge_no;
    logic           sync_ok;
    logic           async_ok;

    always_comb begin
        // edge_cnt counts edges already passed in the active phase; this is the next one
        edge_no    = {1'b0, edge_cnt} + {{CNT_W{1'b0}}, 1'b1};
        sync_ok    = active && sync_done && (edge_no >= SYNC_LIM);
        async_ok   = active && (ack_size != PW_WAIT) && (edge_no >= ASYNC_LIM);
        term_hit   = sync_ok || async_ok;
        // synchronous termination wins over a simultaneous size acknowledge
        term_sync  = sync_ok;
        term_width = sync_ok ? PW_WORD : ack_size;
    end

endmodule

// File: rtl/bcc_lane_steer.sv
// Moves read data from the lanes a narrow port uses down to the low end.
module bcc_lane_steer #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        width,
    output logic [DATA_W-1:0] dout
);
    import bcc_pkg::*;

    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] byte_path;
    logic [DATA_W-1:0] half_path;

    always_comb begin
        byte_path = '0;
        half_path = '0;
        byte_path[BYTE_W-1:0] = din[DATA_W-1 -: BYTE_W];
        half_path[HALF_W-1:0] = din[DATA_W-1 -: HALF_W];
        case (width)
            PW_BYTE: dout = byte_path;
            PW_HALF: dout = half_path;
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FC_W       = 3,
    parameter int SYNC_EDGE  = 1,
    parameter int ASYNC_EDGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FC_W-1:0]   req_fc,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sync,
    output logic [1:0]        rsp_width,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic              bus_rw,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        bus_ack_size,
    input  logic              bus_sync_done
);
    import bcc_pkg::*;

    localparam int MAX_EDGE = (ASYNC_EDGE > SYNC_EDGE) ? ASYNC_EDGE : SYNC_EDGE;
    localparam int CNT_W    = (MAX_EDGE > 1) ? $clog2(MAX_EDGE) : 1;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_EDGE - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              as_n;
        logic              ds_n;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
        logic              rsp_s;
        logic [1:0]        rsp_w;
    } state_t;

    localparam state_t ST_RESET = '{
        phase: PH_IDLE, cnt: '0, addr: '0, fc: '0, wr: 1'b0, wdata: '0,
        as_n: 1'b1, ds_n: 1'b1, rsp_v: 1'b0, rdata: '0, rsp_s: 1'b0, rsp_w: 2'b00
    };

    state_t st_q, st_d;

    logic              term_hit;
    logic              term_sync;
    logic [1:0]        term_width;
    logic [DATA_W-1:0] steered;

    bcc_term_decode #(
        .CNT_W      (CNT_W),
        .SYNC_EDGE  (SYNC_EDGE),
        .ASYNC_EDGE (ASYNC_EDGE)
    ) u_term (
        .active     (st_q.phase == PH_ACTIVE),
        .edge_cnt   (st_q.cnt),
        .sync_done  (bus_sync_done),
        .ack_size   (bus_ack_size),
        .term_hit   (term_hit),
        .term_sync  (term_sync),
        .term_width (term_width)
    );

    bcc_lane_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .din   (bus_din),
        .width (term_width),
        .dout  (steered)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = '0;
                    st_d.addr  = req_addr;
                    st_d.fc    = req_fc;
                    st_d.wr    = req_write;
                    st_d.wdata = req_wdata;
                    st_d.as_n  = 1'b0;
                    // reads strobe data at once, writes one clock later
                    st_d.ds_n  = req_write;
                end
            end
            PH_ACTIVE: begin
                if (term_hit) begin
                    st_d.phase = PH_RECOVER;
                    st_d.as_n  = 1'b1;
                    st_d.ds_n  = 1'b1;
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_s = term_sync;
                    st_d.rsp_w = term_width;
                    st_d.rdata = st_q.wr ? '0 : steered;
                end else begin
                    st_d.ds_n = 1'b0;
                    if (st_q.cnt != CNT_SAT) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_RECOVER: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rdata;
    assign rsp_sync  = st_q.rsp_s;
    assign rsp_width = st_q.rsp_w;
    assign bus_addr  = st_q.addr;
    assign bus_fc    = st_q.fc;
    assign bus_rw    = ~st_q.wr;
    assign bus_as_n  = st_q.as_n;
    assign bus_ds_n  = st_q.ds_n;
    assign bus_dout  = st_q.wdata;
    assign bus_doe   = (st_q.phase == PH_ACTIVE) && st_q.wr;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int FC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_sync,
    input logic [1:0]        rsp_width,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FC_W-1:0]   bus_fc,
    input logic              bus_rw,
    input logic              bus_as_n,
    input logic              bus_ds_n,
    input logic              bus_doe,
    input logic [1:0]        bus_ack_size,
    input logic              bus_sync_done
);

    // R2
    sync_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_sync) |-> $past(!bus_as_n));

    // R3
    async_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_sync) |-> ($past(!bus_as_n) && $past(!bus_as_n, 2)));

    // R4
    width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_width != 2'b00));

    // R5
    no_spurious_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_sync_done || (bus_ack_size != 2'b00)));

    // R6
    sync_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_sync) |-> (rsp_width == 2'b11));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_rw)));

    // R8
    recover_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_as_n && bus_ds_n && !req_ready));

    // R9
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds_n |-> !bus_as_n);

    // R10
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_rw && !bus_as_n));

endmodule

bind bus_cycle_ctrl bcc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FC_W   (FC_W)
) u_bcc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_sync      (rsp_sync),
    .rsp_width     (rsp_width),
    .bus_addr      (bus_addr),
    .bus_fc        (bus_fc),
    .bus_rw        (bus_rw),
    .bus_as_n      (bus_as_n),
    .bus_ds_n      (bus_ds_n),
    .bus_doe       (bus_doe),
    .bus_ack_size  (bus_ack_size),
    .bus_sync_done (bus_sync_done)
);

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_sync;
    logic [1:0]  rsp_width;
    logic [31:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_rw;
    logic        bus_as_n;
    logic        bus_ds_n;
    logic [31:0] bus_dout;
    logic        bus_doe;
    logic [31:0] bus_din = '0;
    logic [1:0]  bus_ack_size = 2'b00;
    logic        bus_sync_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bus_cycle_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_fc        (req_fc),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_sync      (rsp_sync),
        .rsp_width     (rsp_width),
        .bus_addr      (bus_addr),
        .bus_fc        (bus_fc),
        .bus_rw        (bus_rw),
        .bus_as_n      (bus_as_n),
        .bus_ds_n      (bus_ds_n),
        .bus_dout      (bus_dout),
        .bus_doe       (bus_doe),
        .bus_din       (bus_din),
        .bus_ack_size  (bus_ack_size),
        .bus_sync_done (bus_sync_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue a request; returns at the negedge after the accepting edge E0.
    task automatic start_cycle(input logic wr, input logic [31:0] a, input logic [2:0] f,
                               input logic [31:0] wd);
        @(negedge clk);
        req_write = wr; req_addr = a; req_fc = f; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Finish: after the terminating edge, then the recovery clock.
    task automatic check_end(input string tag, input logic s, input logic [1:0] w,
                             input logic [31:0] d);
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_sync"}, 32'(rsp_sync), 32'(s));
        chk({tag, " rsp_width"}, 32'(rsp_width), 32'(w));
        chk({tag, " rsp_rdata"}, rsp_rdata, d);
        bus_sync_done = 1'b0; bus_ack_size = 2'b00;
        @(negedge clk);
        chk({tag, " back to idle"}, 32'({req_ready, rsp_valid}), 32'b10);
    endtask

    task automatic t_reset();
        chk("R1 as_n", 32'(bus_as_n), 32'd1);
        chk("R1 ds_n", 32'(bus_ds_n), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 doe", 32'(bus_doe), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_sync_read();
        bus_din = 32'hA1B2C3D4;
        start_cycle(1'b0, 32'h0000_1230, 3'd5, 32'h0);
        chk("R10 as_n low", 32'(bus_as_n), 32'd0);
        chk("R10 ds_n with as", 32'(bus_ds_n), 32'd0);
        chk("R10 rw read", 32'(bus_rw), 32'd1);
        chk("R10 doe off", 32'(bus_doe), 32'd0);
        chk("R7 addr", bus_addr, 32'h0000_1230);
        chk("R7 fc", 32'(bus_fc), 32'd5);
        bus_sync_done = 1'b1;
        @(negedge clk);
        check_end("R2 sync earliest", 1'b1, 2'b11, 32'hA1B2C3D4);
    endtask

    task automatic t_async_early_ignored();
        bus_din = 32'h11223344;
        start_cycle(1'b0, 32'h0000_2000, 3'd1, 32'h0);
        bus_ack_size = 2'b11;
        @(negedge clk);
        chk("R3 no end at E1", 32'(rsp_valid), 32'd0);
        chk("R3 still active", 32'(bus_as_n), 32'd0);
        @(negedge clk);
        check_end("R3 async at E2", 1'b0, 2'b11, 32'h11223344);
    endtask

    task automatic t_async_narrow(input logic [1:0] w, input logic [31:0] din,
                                  input logic [31:0] exp, input int waits);
        start_cycle(1'b0, 32'h0000_3000, 3'd2, 32'h0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk("R5 wait active", 32'({bus_as_n, bus_ds_n, rsp_valid}), 32'b000);
            chk("R7 addr held", bus_addr, 32'h0000_3000);
        end
        bus_din = din; bus_ack_size = w;
        if (waits == 0) @(negedge clk);
        @(negedge clk);
        check_end("R4 narrow port", 1'b0, w, exp);
    endtask

    task automatic t_priority();
        bus_din = 32'hCAFE_F00D;
        start_cycle(1'b0, 32'h0000_4000, 3'd6, 32'h0);
        @(negedge clk);
        @(negedge clk);
        bus_sync_done = 1'b1; bus_ack_size = 2'b01;
        @(negedge clk);
        check_end("R6 both late", 1'b1, 2'b11, 32'hCAFE_F00D);
        start_cycle(1'b0, 32'h0000_4004, 3'd6, 32'h0);
        bus_sync_done = 1'b1; bus_ack_size = 2'b10;
        @(negedge clk);
        check_end("R6 both at E1", 1'b1, 2'b11, 32'hCAFE_F00D);
    endtask

    task automatic t_write_and_recover();
        start_cycle(1'b1, 32'h0000_5550, 3'd3, 32'hDEAD_BEEF);
        chk("R9 rw write", 32'(bus_rw), 32'd0);
        chk("R9 doe", 32'(bus_doe), 32'd1);
        chk("R9 dout", bus_dout, 32'hDEAD_BEEF);
        chk("R9 ds late", 32'({bus_as_n, bus_ds_n}), 32'b01);
        @(negedge clk);
        chk("R9 ds asserted", 32'({bus_as_n, bus_ds_n}), 32'b00);
        chk("R7 rw held", 32'(bus_rw), 32'd0);
        bus_ack_size = 2'b11;
        @(negedge clk);
        chk("R8 strobes off", 32'({bus_as_n, bus_ds_n}), 32'b11);
        chk("R8 not ready", 32'(req_ready), 32'd0);
        chk("R8 rsp", 32'(rsp_valid), 32'd1);
        bus_ack_size = 2'b00;
        req_write = 1'b0; req_addr = 32'h0000_6660; req_fc = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        chk("R8 held request not started", 32'({bus_as_n, req_ready}), 32'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 request starts next", 32'(bus_as_n), 32'd0);
        chk("R8 new addr", bus_addr, 32'h0000_6660);
        bus_sync_done = 1'b1; bus_din = 32'h0BAD_0BAD;
        @(negedge clk);
        check_end("R8 follow-on", 1'b1, 2'b11, 32'h0BAD_0BAD);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_read();
        t_async_early_ignored();
        t_async_narrow(2'b01, 32'h5A33_4455, 32'h0000_005A, 3);
        t_async_narrow(2'b10, 32'h9876_1234, 32'h0000_9876, 0);
        t_async_narrow(2'b11, 32'h0102_0304, 32'h0102_0304, 1);
        t_priority();
        t_write_and_recover();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule